// File: doc/BRIEF.md
# External Bus Cycle Wait-State Sequencer

This block runs one external memory access at a time on behalf of a processor core. When it is idle and a request arrives, it raises an address latch strobe for one clock. After an optional one-clock delay it pulls the active-low read or write command low. The command stays low for a programmed number of memory wait states. After that it stays low for as long as the external device holds its active-low READY line high. Once the command is released, the block adds a gap for bus tri-state and turnaround. The length of that gap depends on whether the bus is multiplexed. After the gap the block pulses `done` and can take the next request.

The request and the cycle settings are captured in the clock where the request is accepted. The READY mode input chooses how READY is taken. In synchronous mode the raw input is used at the clock edge. In asynchronous mode READY passes through an internal flop synchronizer, two stages by default, before it is used. READY is only evaluated at the sampling point inside the command phase, so a device that releases READY late does not disturb the tail of the cycle or the next cycle.

Top module: `ext_bus_cycle_ctl`

## Requirements
- R1: While reset is asserted, and after it is released with no request, `ale` is 0, `rd_n` and `wr_n` are 1, `busy` is 0 and `done` is 0.
- R2: A request seen while idle starts a cycle. `ale` is then high for exactly one clock, and both command strobes are high during that clock.
- R3: With `cfg_cmd_delay`=1 there is exactly one clock with both strobes high between the `ale` clock and the command fall. With 0 the command falls in the clock right after `ale`.
- R4: If READY is low at the sampling point, the command is low for exactly `cfg_wait`+1 clocks, for every `cfg_wait` from 0 to its maximum value.
- R5: The READY sampling point is the end of the last programmed command clock. Each sample that finds READY high (not ready) adds one command clock and samples again. A low READY before the sampling point does not shorten the cycle.
- R6: With `cfg_async_rdy`=0 the READY level at the sampling edge itself is used. With `cfg_async_rdy`=1 the level used is the one present two clock edges earlier (two-stage synchronizer).
- R7: READY levels after the command has risen, including a release to high, do not change the length of the tail gap or of the next cycle.
- R8: After the command rises, the block adds one tri-state clock when `cfg_mux`=1 and one turnaround clock when `cfg_turn`=1. The gap is therefore 0, 1 or 2 clocks, and `busy` stays high through it.
- R9: `done` is high for exactly one clock, the first clock after the last command or gap clock. `busy` is 0 in that clock, and a request in that clock starts the next cycle.
- R10: With `req_write`=1 only `wr_n` goes low in the command phase. With `req_write`=0 only `rd_n` goes low. The other strobe stays high for the whole cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request for one bus cycle, accepted while idle |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| cfg_wait | input | WAIT_W | Programmed memory wait states |
| cfg_cmd_delay | input | 1 | 1 = delay command fall by one clock |
| cfg_async_rdy | input | 1 | 1 = READY through synchronizer, 0 = direct |
| cfg_mux | input | 1 | 1 = multiplexed bus, adds tri-state clock |
| cfg_turn | input | 1 | 1 = add turnaround clock |
| rdy_n | input | 1 | Active-low READY from the device |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Active-low read command |
| wr_n | output | 1 | Active-low write command |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | One-clock pulse when the cycle has fully ended |

## Verification
Two events can land on the same edge. The first is the READY sampling point and the expiry of the last programmed wait state. The second is the synchronizer delivering a stale READY level while the command is still low. The bench sweeps wait states from zero to the maximum, the delay, the READY mode, and both gap settings. It schedules READY levels per clock from the requirement timing, shifting them two clocks earlier in asynchronous mode. It holds READY low ahead of the sampling point and releases it high right after the final sample, so that early or late READY levels would visibly change the phase lengths. Each cycle is judged by counting the address, pre-command, command and gap clocks against arithmetic from the settings.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;
   typedef enum logic [2:0] {
      S_IDLE = 3'd0,
      S_ALE  = 3'd1,
      S_DLY  = 3'd2,
      S_CMD  = 3'd3,
      S_TRI  = 3'd4,
      S_TURN = 3'd5
   } bus_st_e;
endpackage

// File: rtl/bus_rdy_front.sv
module bus_rdy_front #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_sel,
   input  logic rdy_n_in,
   output logic rdy_n_out
);
   logic [STAGES-1:0] sq;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("bus_rdy_front: STAGES must be at least 2");
      end
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sq[0] <= 1'b1;
               else        sq[0] <= rdy_n_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sq[g] <= 1'b1;
               else        sq[g] <= sq[g-1];
            end
         end
      end
   endgenerate

   assign rdy_n_out = async_sel ? sq[STAGES-1] : rdy_n_in;

   logic [1:0] warm;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           warm <= 2'd0;
      else if (warm != 2'd3) warm <= warm + 2'd1;
   end

   generate
      if (STAGES == 2) begin : g_lag_chk
         p_sync_lag_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (async_sel && warm >= 2'd2) |-> (rdy_n_out == $past(rdy_n_in, 2)));
      end
   endgenerate
   p_sync_direct_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !async_sel |-> (rdy_n_out == rdy_n_in));
endmodule

// File: rtl/bus_wait_ctr.sv
module bus_wait_ctr #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic         zero
);
   logic [W-1:0] cnt;

   generate
      if (W < 1) begin : g_bad_w
         $error("bus_wait_ctr: W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (load)           cnt <= load_val;
      else if (dec && cnt != '0) cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);

   p_load_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (zero == ($past(load_val) == '0)));
   p_hold_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (zero && !load) |=> zero);
endmodule

// File: rtl/ext_bus_cycle_ctl.sv
module ext_bus_cycle_ctl
   import bus_seq_pkg::*;
#(
   parameter int WAIT_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [WAIT_W-1:0] cfg_wait,
   input  logic              cfg_cmd_delay,
   input  logic              cfg_async_rdy,
   input  logic              cfg_mux,
   input  logic              cfg_turn,
   input  logic              rdy_n,
   output logic              ale,
   output logic              rd_n,
   output logic              wr_n,
   output logic              busy,
   output logic              done
);
   bus_st_e st, st_nx;
   logic    wr_q, dly_q, mux_q, turn_q;
   logic    rdy_n_eff, rdy_ok, cnt_zero, cmd_act, accept, done_q;

   bus_rdy_front #(.STAGES(SYNC_STAGES)) u_front (
      .clk       (clk),
      .rst_n     (rst_n),
      .async_sel (cfg_async_rdy),
      .rdy_n_in  (rdy_n),
      .rdy_n_out (rdy_n_eff)
   );

   assign accept  = (st == S_IDLE) && req_valid;
   assign cmd_act = (st == S_CMD);
   assign rdy_ok  = !rdy_n_eff;

   bus_wait_ctr #(.W(WAIT_W)) u_wait (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .load_val (cfg_wait),
      .dec      (cmd_act && !cnt_zero),
      .zero     (cnt_zero)
   );

   always_comb begin
      st_nx = st;
      unique case (st)
         S_IDLE: if (req_valid) st_nx = S_ALE;
         S_ALE:  st_nx = dly_q ? S_DLY : S_CMD;
         S_DLY:  st_nx = S_CMD;
         S_CMD: begin
            if (cnt_zero && rdy_ok) begin
               if (mux_q)       st_nx = S_TRI;
               else if (turn_q) st_nx = S_TURN;
               else             st_nx = S_IDLE;
            end
         end
         S_TRI:  st_nx = turn_q ? S_TURN : S_IDLE;
         S_TURN: st_nx = S_IDLE;
         default: st_nx = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= S_IDLE;
         done_q <= 1'b0;
         wr_q   <= 1'b0;
         dly_q  <= 1'b0;
         mux_q  <= 1'b0;
         turn_q <= 1'b0;
      end else begin
         st     <= st_nx;
         done_q <= (st != S_IDLE) && (st_nx == S_IDLE);
         if (accept) begin
            wr_q   <= req_write;
            dly_q  <= cfg_cmd_delay;
            mux_q  <= cfg_mux;
            turn_q <= cfg_turn;
         end
      end
   end

   assign ale  = (st == S_ALE);
   assign rd_n = !(cmd_act && !wr_q);
   assign wr_n = !(cmd_act && wr_q);
   assign busy = (st != S_IDLE);
   assign done = done_q;

   p_ale_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ale |=> !ale);
   p_ale_strobes_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ale |-> (rd_n && wr_n));
   p_cmd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_act && !(cnt_zero && rdy_ok)) |=> cmd_act);
   p_gap_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(cmd_act) && !mux_q && !turn_q) |-> done);
   p_gap_some_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(cmd_act) && (mux_q || turn_q)) |-> (!done && busy));
   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (rd_n || wr_n));
endmodule

// File: tb/sim_ext_bus_cycle_ctl.sv
module sim_ext_bus_cycle_ctl;
   localparam int WAIT_W = 4;
   localparam int WMAX   = (1 << WAIT_W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [WAIT_W-1:0] cfg_wait = '0;
   logic cfg_cmd_delay = 1'b0, cfg_async_rdy = 1'b0, cfg_mux = 1'b0, cfg_turn = 1'b0;
   logic rdy_n = 1'b0;
   logic ale, rd_n, wr_n, busy, done;

   int checks = 0, failures = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   ext_bus_cycle_ctl #(.WAIT_W(WAIT_W), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .cfg_wait(cfg_wait), .cfg_cmd_delay(cfg_cmd_delay), .cfg_async_rdy(cfg_async_rdy),
      .cfg_mux(cfg_mux), .cfg_turn(cfg_turn), .rdy_n(rdy_n),
      .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .busy(busy), .done(done)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // READY level wanted at command clock cc (1-based)
   function automatic logic rdy_for(int cc, int w, int nr);
      if (cc < w + 1)        return 1'b0;
      if (cc <= w + nr)      return 1'b1;
      if (cc == w + 1 + nr)  return 1'b0;
      return 1'b1;
   endfunction

   task automatic run_cycle(input int w, input bit dly, input bit asy, input bit mx,
                            input bit tn, input int nr, input bit wr);
      int j, n_ale, n_pre, n_cmd, n_post, n_bad, lag, guard;
      bit seen_done;
      lag = asy ? 2 : 0;
      n_ale = 0; n_pre = 0; n_cmd = 0; n_post = 0; n_bad = 0; seen_done = 0;
      cfg_wait = WAIT_W'(w); cfg_cmd_delay = dly; cfg_async_rdy = asy;
      cfg_mux = mx; cfg_turn = tn; req_write = wr; req_valid = 1'b1;
      j = -1;
      rdy_n = rdy_for(j + lag - int'(dly), w, nr);
      guard = 0;
      while (!seen_done && guard < 100) begin
         @(negedge clk);
         j++; guard++;
         if (done) begin
            seen_done = 1;
            check("R9 busy during done", int'(busy), 0);
         end else if (ale) begin
            n_ale++;
            req_valid = 1'b0;
            if (!rd_n || !wr_n) n_bad++;
         end else if ((wr && !wr_n) || (!wr && !rd_n)) begin
            n_cmd++;
            if (wr ? !rd_n : !wr_n) n_bad++;
         end else if (busy) begin
            if (n_cmd == 0) n_pre++; else n_post++;
            if (!rd_n || !wr_n) n_bad++;
         end
         rdy_n = rdy_for(j + lag - int'(dly), w, nr);
      end
      check("R9 done seen", int'(seen_done), 1);
      check("R2 ale clocks", n_ale, 1);
      check("R3 pre-command clocks", n_pre, int'(dly));
      check("R4/R5/R6 command clocks", n_cmd, w + 1 + nr);
      check("R7/R8 gap clocks", n_post, int'(mx) + int'(tn));
      check("R10 wrong strobe clocks", n_bad, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 ale in reset", int'(ale), 0);
      check("R1 rd_n in reset", int'(rd_n), 1);
      check("R1 wr_n in reset", int'(wr_n), 1);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 busy idle", int'(busy), 0);
      check("R1 done idle", int'(done), 0);
      check("R1 ale idle", int'(ale), 0);
      for (int wi = 0; wi < 4; wi++)
         for (int d = 0; d < 2; d++)
            for (int a = 0; a < 2; a++)
               for (int m = 0; m < 2; m++)
                  for (int t = 0; t < 2; t++)
                     for (int nr = 0; nr < 3; nr++)
                        run_cycle((wi == 3) ? WMAX : wi, d[0], a[0], m[0], t[0], nr,
                                  ((wi + nr + m) % 2) == 1);
      // R9: no request after done keeps the block idle
      repeat (4) @(negedge clk);
      check("R9 stays idle", int'(busy), 0);
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++; failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule